// File: doc/BRIEF.md
# AC-link Codec Input Frame Serializer

This block is the codec-side source of the serial input frame on an AC'97-style audio link. When it sees the frame sync go high, it forms one 256-bit frame and sends it MSB first on its serial data line, one bit per bit clock. The frame is a 16-bit tag slot followed by twelve 20-bit slots. The tag slot holds a codec-ready flag and a valid flag for each slot that carries data. Slot 1 echoes the index of a register read that the controller asked for in the previous frame, together with the per-slot sample-request flags. Slot 2 returns the read data. Slots 3 to 10 carry 18-bit capture samples.

The surrounding codec logic supplies the register access seen in the previous frame (valid, read or write, index, read data), eight sample-request flags, a variable-rate enable, and eight capture samples with their valid flags. The serializer captures all of them at frame start. Until the clocks-stable input has been seen high after a cold reset, the codec is not ready: every frame goes out as all zeros and every access is ignored.

Top module: `acInFrameTx`

## Requirements
- R1: The tag slot occupies frame bits 0..15 (the first bits sent) and is sent MSB first. Its bit 15 is codec ready, bit 14 is slot 1 valid, bit 13 is slot 2 valid, and bits 12 down to 5 are the valid flags of slots 3 to 10 (capValid[0] at bit 12, capValid[7] at bit 5). Bits 4:0 are zero.
- R2: After reset the serial line is 0 and codec ready is clear. While codec ready is clear, every frame is all zeros and access, request and capture inputs have no effect. Codec ready is set once clocksStable has been high on a clock edge before the frame starts, and it stays set until reset, even if clocksStable drops.
- R3: When codec ready is set and the access is a valid read, slot 1 is {1'b0, accIndex[6:0], SR3..SR10, 4'b0000}, with the index in slot bits 18:12. Slot 1 valid and slot 2 valid are set.
- R4: A write access (accIsRead=0) or no access (accValid=0) leaves slot 1 and slot 2 valid clear, and leaves the index field and slot 2 all zero.
- R5: For a read, slot 2 is rdData[15:0] in bits 19:4, with bits 3:0 zero.
- R6: The slot 1 bits 11:4 carry slotReq[0] (slot 3) at bit 11 down to slotReq[7] (slot 10) at bit 4 when varRateEn is 1. They are all zero when varRateEn is 0, and they are sent whether or not a read is echoed.
- R7: Capture slot k (k=3..10) carries capSample[(k-3)*18 +: 18] in bits 19:2, MSB first, with bits 1:0 zero, when capValid[k-3] is 1. Otherwise the slot is all zeros.
- R8: Slots 11 and 12 are always all zeros.
- R9: Tag bit 15 appears on sdataIn after the first rising bit-clock edge at which frameSync is seen going from 0 to 1. The following 255 edges send the remaining bits. After that the line stays 0 until the next frame sync rise.
- R10: All inputs are captured at the frame-start edge. Changes during the frame do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; the line changes on its rising edge |
| rstN | input | 1 | Active-low cold reset, asynchronous |
| frameSync | input | 1 | Frame sync from the controller; a 0 to 1 change starts a frame |
| clocksStable | input | 1 | High once codec clocks and supplies are stable |
| accValid | input | 1 | A register access was received in the previous frame |
| accIsRead | input | 1 | 1 for a read access, 0 for a write |
| accIndex | input | 7 | Register index of the access |
| rdData | input | 16 | Register read data to return |
| slotReq | input | 8 | Per-slot sample-request flags, bit 0 = slot 3 |
| varRateEn | input | 1 | Variable-rate enable; when 0, the request flags are sent as zero |
| capSample | input | 144 | Eight 18-bit capture samples, sample 0 (slot 3) in bits 17:0 |
| capValid | input | 8 | Capture valid flags, bit 0 = slot 3 |
| sdataIn | output | 1 | Serial input-frame data toward the controller |

## Verification
The hardest case to reach from the ports is a frame whose inputs change while it is being sent. Its content must come only from the inputs present at the sync edge, and the change has to land strictly after that edge. In most frames the stimulus redraws every input at random on the falling edge just after frame start. It then compares all 256 captured bits against a model that uses the snapshot taken before the redraw. Directed frames sent before the ready input rises, and again after that input falls, cover the gating and the sticky ready flag.

// File: rtl/acin_pkg.sv
package acin_pkg;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int SLOT_COUNT = 12;
  localparam int CAP_COUNT  = 8;
  localparam int SAMP_BITS  = 18;
  localparam int IDX_BITS   = 7;
  localparam int DATA_BITS  = 16;

  typedef struct packed {
    logic load;   // capture inputs and start a frame
    logic shift;  // advance the frame by one bit
  } txStrobe_t;
endpackage

// File: rtl/acin_ctrl.sv
module acin_ctrl
  import acin_pkg::*;
#(
  parameter int FRAME_W = 256
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameSync,
  input  logic      clocksStable,
  output txStrobe_t strb,
  output logic      codecReady
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic             syncPrev;
  logic             active;
  logic [CNT_W-1:0] bitCnt;
  logic             syncRise;

  assign syncRise   = frameSync && !syncPrev;
  assign strb.load  = syncRise;
  assign strb.shift = active && !syncRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev   <= 1'b0;
      codecReady <= 1'b0;
      active     <= 1'b0;
      bitCnt     <= '0;
    end else begin
      syncPrev <= frameSync;
      if (clocksStable) codecReady <= 1'b1;
      if (syncRise) begin
        active <= 1'b1;
        bitCnt <= '0;
      end else if (active) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(FRAME_W - 1)) active <= 1'b0;
      end
    end
  end

  // R2: ready never falls back without a reset
  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    codecReady |=> codecReady);

  // R9: a frame lasts exactly FRAME_W bit clocks unless restarted
  assert_frame_len_R9: assert property (@(posedge clk) disable iff (!rstN)
    (active && bitCnt == CNT_W'(FRAME_W - 1) && !syncRise) |=> !active);

  // R9: loading and shifting never happen together
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shift}));
endmodule

// File: rtl/acin_datapath.sv
module acin_datapath
  import acin_pkg::*;
#(
  parameter int TAG_W   = TAG_BITS,
  parameter int SLOT_W  = SLOT_BITS,
  parameter int N_SLOTS = SLOT_COUNT,
  parameter int N_CAP   = CAP_COUNT,
  parameter int SAMP_W  = SAMP_BITS,
  parameter int IDX_W   = IDX_BITS,
  parameter int DATA_W  = DATA_BITS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  txStrobe_t               strb,
  input  logic                    codecReady,
  input  logic                    accValid,
  input  logic                    accIsRead,
  input  logic [IDX_W-1:0]        accIndex,
  input  logic [DATA_W-1:0]       rdData,
  input  logic [N_CAP-1:0]        slotReq,
  input  logic                    varRateEn,
  input  logic [N_CAP*SAMP_W-1:0] capSample,
  input  logic [N_CAP-1:0]        capValid,
  output logic                    sdataOut
);
  localparam int FRAME_W = TAG_W + N_SLOTS * SLOT_W;
  localparam int S1_PAD  = SLOT_W - 1 - IDX_W - N_CAP;
  localparam int S2_PAD  = SLOT_W - DATA_W;
  localparam int CAP_PAD = SLOT_W - SAMP_W;
  localparam int TAIL_W  = (N_SLOTS - 2 - N_CAP) * SLOT_W;
  localparam int TAG_PAD = TAG_W - 3 - N_CAP;

  logic                    readHit;
  logic [N_CAP-1:0]        srBits;
  logic [N_CAP-1:0]        capTag;
  logic [N_CAP*SLOT_W-1:0] capSlots;
  logic [TAG_W-1:0]        tagSlot;
  logic [SLOT_W-1:0]       slotOne;
  logic [SLOT_W-1:0]       slotTwo;
  logic [FRAME_W-1:0]      frameNext;
  logic [FRAME_W-1:0]      shiftReg;

  assign readHit = codecReady && accValid && accIsRead;

  for (genvar i = 0; i < N_CAP; i++) begin : gCap
    // slot i+3 sits at position i after the two register slots
    assign srBits[N_CAP-1-i] = codecReady && varRateEn && slotReq[i];
    assign capTag[N_CAP-1-i] = codecReady && capValid[i];
    assign capSlots[(N_CAP-1-i)*SLOT_W +: SLOT_W] =
      (codecReady && capValid[i]) ? {capSample[i*SAMP_W +: SAMP_W], {CAP_PAD{1'b0}}}
                                  : '0;
  end

  assign tagSlot = {codecReady, readHit, readHit, capTag, {TAG_PAD{1'b0}}};
  assign slotOne = {1'b0, (readHit ? accIndex : {IDX_W{1'b0}}), srBits, {S1_PAD{1'b0}}};
  assign slotTwo = readHit ? {rdData, {S2_PAD{1'b0}}} : '0;
  assign frameNext = {tagSlot, slotOne, slotTwo, capSlots, {TAIL_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shiftReg <= '0;
    else if (strb.load)  shiftReg <= frameNext;
    else if (strb.shift) shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
  end

  assign sdataOut = shiftReg[FRAME_W-1];

  // R2: a frame started before ready carries nothing
  assert_ready_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !codecReady) |=> (shiftReg == '0));

  // R4: a write access never marks slot 1 or slot 2 valid
  assert_write_no_echo_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && accValid && !accIsRead) |=> (shiftReg[FRAME_W-2 -: 2] == 2'b00));

  // R8: the trailing slots load as zero
  assert_tail_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (shiftReg[TAIL_W-1:0] == '0));

  // R1: the reserved tag bits load as zero
  assert_tag_reserved_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (shiftReg[FRAME_W-TAG_W +: TAG_PAD] == '0));
endmodule

// File: rtl/acInFrameTx.sv
module acInFrameTx
  import acin_pkg::*;
#(
  parameter int TAG_W   = TAG_BITS,
  parameter int SLOT_W  = SLOT_BITS,
  parameter int N_SLOTS = SLOT_COUNT,
  parameter int N_CAP   = CAP_COUNT,
  parameter int SAMP_W  = SAMP_BITS,
  parameter int IDX_W   = IDX_BITS,
  parameter int DATA_W  = DATA_BITS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameSync,
  input  logic                    clocksStable,
  input  logic                    accValid,
  input  logic                    accIsRead,
  input  logic [IDX_W-1:0]        accIndex,
  input  logic [DATA_W-1:0]       rdData,
  input  logic [N_CAP-1:0]        slotReq,
  input  logic                    varRateEn,
  input  logic [N_CAP*SAMP_W-1:0] capSample,
  input  logic [N_CAP-1:0]        capValid,
  output logic                    sdataIn
);
  localparam int FRAME_W = TAG_W + N_SLOTS * SLOT_W;

  txStrobe_t strb;
  logic      codecReady;

  acin_ctrl #(.FRAME_W(FRAME_W)) uCtrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .clocksStable(clocksStable),
    .strb(strb), .codecReady(codecReady)
  );

  acin_datapath #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS), .N_CAP(N_CAP),
    .SAMP_W(SAMP_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .codecReady(codecReady),
    .accValid(accValid), .accIsRead(accIsRead), .accIndex(accIndex),
    .rdData(rdData), .slotReq(slotReq), .varRateEn(varRateEn),
    .capSample(capSample), .capValid(capValid), .sdataOut(sdataIn)
  );
endmodule

// File: tb/tb_acInFrameTx.sv
module tb_acInFrameTx;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         frameSync = 1'b0;
  logic         clocksStable = 1'b0;
  logic         accValid = 1'b0;
  logic         accIsRead = 1'b0;
  logic [6:0]   accIndex = '0;
  logic [15:0]  rdData = '0;
  logic [7:0]   slotReq = '0;
  logic         varRateEn = 1'b0;
  logic [143:0] capSample = '0;
  logic [7:0]   capValid = '0;
  logic         sdataIn;

  int  errors = 0;
  int  checks = 0;
  bit  readyModel = 0;
  bit  finished = 0;

  acInFrameTx dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic randomizeInputs();
    accValid  = 1'($urandom);
    accIsRead = 1'($urandom);
    accIndex  = 7'($urandom);
    rdData    = 16'($urandom);
    slotReq   = 8'($urandom);
    varRateEn = 1'($urandom);
    capValid  = 8'($urandom);
    for (int i = 0; i < 8; i++) capSample[i*18 +: 18] = 18'($urandom);
  endtask

  // Expected frame from the requirements (R1, R3..R8), frame bit 255 sent first
  function automatic logic [255:0] expFrame();
    logic [15:0]  tag;
    logic [19:0]  s1;
    logic [19:0]  s2;
    logic [159:0] caps;
    bit rd;
    tag = '0; s1 = '0; s2 = '0; caps = '0;
    if (readyModel) begin
      rd = accValid && accIsRead;
      tag[15] = 1'b1;
      tag[14] = rd;
      tag[13] = rd;
      for (int i = 0; i < 8; i++) begin
        tag[12-i] = capValid[i];
        s1[11-i]  = varRateEn && slotReq[i];
        if (capValid[i]) caps[(7-i)*20 +: 20] = {capSample[i*18 +: 18], 2'b00};
      end
      if (rd) begin
        s1[18:12] = accIndex;
        s2 = {rdData, 4'h0};
      end
    end
    return {tag, s1, s2, caps, 40'h0};
  endfunction

  task automatic runFrame(input string s1Req, input bit scramble);
    logic [255:0] exp;
    logic [255:0] got;
    @(negedge clk);
    frameSync = 1'b1;
    exp = expFrame();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      got[255-i] = sdataIn;
      if (i == 0) begin
        frameSync = 1'b0;
        if (scramble) randomizeInputs();
      end
    end
    chk("R1 tag slot", {240'h0, got[255:240]}, {240'h0, exp[255:240]});
    chk(s1Req, {236'h0, got[239:220]}, {236'h0, exp[239:220]});
    chk("R5 slot2", {236'h0, got[219:200]}, {236'h0, exp[219:200]});
    chk("R7 capture slots", {96'h0, got[199:40]}, {96'h0, exp[199:40]});
    chk("R8 slots 11-12", {216'h0, got[39:0]}, {216'h0, exp[39:0]});
    if (scramble) chk("R10 whole frame after mid-frame change", got, exp);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 idle line after frame", {255'h0, sdataIn}, 256'h0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R2 line low in reset", {255'h0, sdataIn}, 256'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 line low after reset", {255'h0, sdataIn}, 256'h0);

    // R2: not ready yet, busy inputs must be ignored
    accValid = 1; accIsRead = 1; accIndex = 7'h26; rdData = 16'hBEEF;
    varRateEn = 1; slotReq = 8'hFF; capValid = 8'hFF; capSample = '1;
    runFrame("R2 slot1 before ready", 1'b0);
    runFrame("R2 slot1 before ready scrambled", 1'b1);

    // become ready
    @(negedge clk); clocksStable = 1'b1;
    @(negedge clk); readyModel = 1;
    repeat (2) @(negedge clk);

    // R3/R6: read echo with request flags forwarded
    accValid = 1; accIsRead = 1; accIndex = 7'h7F; rdData = 16'hFFFF;
    varRateEn = 1; slotReq = 8'b1000_0001; capValid = 8'h00;
    runFrame("R3 read echo with R6 flags", 1'b0);

    // R6: flags forced zero with variable rate off
    varRateEn = 0; slotReq = 8'hFF; accIndex = 7'h2A; rdData = 16'h8001;
    runFrame("R6 flags zero when disabled", 1'b0);

    // R4: write gives no echo but flags still sent
    accIsRead = 0; varRateEn = 1; slotReq = 8'h5A;
    runFrame("R4 write no echo", 1'b0);
    accValid = 0; accIsRead = 1;
    runFrame("R4 no access no echo", 1'b0);

    // R7: extreme samples, alternating valid flags
    capValid = 8'b0101_0101;
    for (int i = 0; i < 8; i++) capSample[i*18 +: 18] = (i % 2 == 0) ? 18'h3FFFF : 18'h20001;
    runFrame("R7 slot1 extremes", 1'b0);
    capValid = 8'hFF;
    runFrame("R7 slot1 all valid", 1'b0);

    // R2: ready stays set after the stable input drops
    clocksStable = 1'b0;
    randomizeInputs();
    runFrame("R2 sticky ready", 1'b0);

    // random frames, most with inputs changed just after frame start (R10)
    for (int n = 0; n < 40; n++) begin
      randomizeInputs();
      runFrame("R3/R6 random slot1", (n % 4) != 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule